// File: doc/BRIEF.md
# Four-Bit Ripple Arithmetic Logic Unit

This block is a purely combinational four-bit arithmetic logic unit. Two operands, a three-bit function code and a carry input go in. A four-bit result and a carry output come out. The top bit of the function code chooses between two groups of operations. When it is low, a bitwise logic block produces the result. When it is high, a chain of full adders produces the result.

Every arithmetic operation uses the same adder chain. The second adder input is always operand B. A per-bit selector sets the first adder input to one of four values: the inverse of A, all zeros, A itself, or all ones. The carry input then picks between the two variants of each operation. This gives eight arithmetic micro-operations: subtract with and without borrow, pass B, increment B, add, add with carry, and decrement B. Together with the four logic operations there are twelve distinct functions. Carries travel from bit 0 up to bit 3, and the carry leaving bit 3 is the carry output.

Top module: `alu4_ripple`

## Requirements
- R1: With func[2]=0, the carry input has no effect on `res`, and `cout` is 0.
- R2: func=000 gives res = opa OR opb.
- R3: func=001 gives res = NOT(opa XOR opb), bit by bit.
- R4: func=010 gives res = opa AND opb.
- R5: func=011 gives res = opa XOR opb.
- R6: func=100 gives {cout,res} = (~opa) + opb + cin. With cin=1 the result is opb − opa modulo 16.
- R7: func=101 gives {cout,res} = opb + cin. With cin=0 this is opb unchanged; with cin=1 it is opb+1.
- R8: func=110 gives {cout,res} = opa + opb + cin.
- R9: func=111 gives {cout,res} = opb + 4'b1111 + cin. With cin=0 this is opb−1; with cin=1 it is opb unchanged with cout=1.
- R10: In arithmetic mode, `cout` is the carry out of bit 3. Each stage computes sum = x⊕y⊕c and carry = xy+xc+yc, and each stage's carry feeds the next stage. A carry that enters bit 0 can therefore reach `cout` through all four stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B, always the second adder input |
| func | input | 3 | Function code: bit 2 selects arithmetic, bits 1:0 select the operation |
| cin | input | 1 | Carry into bit 0; has no effect in logic mode |
| res | output | 4 | Result |
| cout | output | 1 | Carry out of bit 3 in arithmetic mode, 0 in logic mode |

## Verification
The hardest case to reach is a carry that enters at bit 0 and travels through all four stages to `cout`. This needs every stage to propagate, for example add with carry on A=15, B=0, or increment on B=15. Random operands rarely produce it.

The bench sweeps every function code and carry value over all 256 operand pairs, so each full-length ripple path is covered. It then adds random vectors and directed cases at the ends of the operand range.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  // Encodings of func[1:0] for the adder operand selector
  localparam logic [1:0] OPX_NOTA = 2'b00;
  localparam logic [1:0] OPX_ZERO = 2'b01;
  localparam logic [1:0] OPX_A    = 2'b10;
  localparam logic [1:0] OPX_ONES = 2'b11;
  // Encodings of func[1:0] for the logic block
  localparam logic [1:0] LG_OR    = 2'b00;
  localparam logic [1:0] LG_XNOR  = 2'b01;
  localparam logic [1:0] LG_AND   = 2'b10;
  localparam logic [1:0] LG_XOR   = 2'b11;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
  import alu4_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       a_bit,
  output logic       x_bit
);
  always_comb begin
    unique case (sel)
      OPX_NOTA: x_bit = ~a_bit;
      OPX_ZERO: x_bit = 1'b0;
      OPX_A:    x_bit = a_bit;
      default:  x_bit = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu4_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       a_bit,
  input  logic       b_bit,
  output logic       z_bit
);
  always_comb begin
    unique case (sel)
      LG_OR:   z_bit = a_bit | b_bit;
      LG_XNOR: z_bit = ~(a_bit ^ b_bit);
      LG_AND:  z_bit = a_bit & b_bit;
      default: z_bit = a_bit ^ b_bit;
    endcase
  end
endmodule

// File: rtl/alu_fa_bit.sv
module alu_fa_bit (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  // R10: one ripple stage
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (x & ci) | (y & ci);
  end
endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       func,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int CW = WIDTH + 1;

  logic [WIDTH-1:0] fa_x;
  logic [WIDTH-1:0] fa_s;
  logic [WIDTH-1:0] lg_z;
  logic [CW-1:0]    carry;
  logic             arith;

  assign arith    = func[2];
  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_opnd_sel u_sel (
      .sel   (func[1:0]),
      .a_bit (opa[i]),
      .x_bit (fa_x[i])
    );
    alu_fa_bit u_fa (
      .x  (fa_x[i]),
      .y  (opb[i]),
      .ci (carry[i]),
      .s  (fa_s[i]),
      .co (carry[i+1])
    );
    alu_logic_unit u_lg (
      .sel   (func[1:0]),
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .z_bit (lg_z[i])
    );
    assign res[i] = arith ? fa_s[i] : lg_z[i];
  end

  assign cout = arith & carry[WIDTH];

  // Checks against a word-level reference sum, independent of the ripple chain
  logic [WIDTH-1:0] chk_x;
  logic [CW-1:0]    chk_sum;
  always_comb begin
    unique case (func[1:0])
      OPX_NOTA: chk_x = ~opa;
      OPX_ZERO: chk_x = '0;
      OPX_A:    chk_x = opa;
      default:  chk_x = '1;
    endcase
    chk_sum = {1'b0, chk_x} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    if (!$isunknown({opa, opb, func, cin})) begin
      // R10
      arith_sum_chk: assert (!arith || ({cout, res} == chk_sum))
        else $error("arith result mismatch");
      // R1
      logic_cout_chk: assert (arith || (cout == 1'b0))
        else $error("cout set in logic mode");
      // R7
      pass_b_chk: assert (!(func == 3'b101 && !cin) || (res == opb && !cout))
        else $error("pass B wrong");
      // R9
      pass_b_hi_chk: assert (!(func == 3'b111 && cin) || (res == opb && cout))
        else $error("pass B with carry wrong");
    end
  end
endmodule

// File: tb/test_alu4_ripple.sv
module test_alu4_ripple;
  logic       clk;
  logic [3:0] opa, opb, res;
  logic [2:0] func;
  logic       cin, cout;
  int         n_run, n_fail;
  bit         done;

  alu4_ripple i_alu4_ripple (
    .opa(opa), .opb(opb), .func(func), .cin(cin), .res(res), .cout(cout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [4:0] model(input logic [3:0] a, input logic [3:0] b,
                                      input logic [2:0] f, input logic c);
    int s;
    if (!f[2]) begin
      case (f[1:0])
        2'b00:   return {1'b0, a | b};
        2'b01:   return {1'b0, ~(a ^ b)};
        2'b10:   return {1'b0, a & b};
        default: return {1'b0, a ^ b};
      endcase
    end
    case (f[1:0])
      2'b00:   s = (15 - int'(a)) + int'(b) + int'(c);
      2'b01:   s = int'(b) + int'(c);
      2'b10:   s = int'(a) + int'(b) + int'(c);
      default: s = int'(b) + 15 + int'(c);
    endcase
    return 5'(s % 32);
  endfunction

  function automatic string tag(input logic [2:0] f);
    case (f)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b100: return "R6";
      3'b101: return "R7";
      3'b110: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] a, input logic [3:0] b,
                       input logic [2:0] f, input logic c, input string req);
    logic [4:0] exp;
    @(negedge clk);
    opa = a; opb = b; func = f; cin = c;
    #1;
    exp = model(a, b, f, c);
    n_run++;
    if ({cout, res} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d f=%b c=%b got {cout,res}=%b expected %b",
               req, a, b, f, c, {cout, res}, exp);
    end
  endtask

  initial begin
    logic [3:0] r0;
    n_run = 0; n_fail = 0; done = 0;
    opa = '0; opb = '0; func = '0; cin = 1'b0;
    // initial state: OR of zeros
    apply(4'd0, 4'd0, 3'b000, 1'b0, "R2");
    // exhaustive sweep
    for (int f = 0; f < 8; f++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            apply(4'(a), 4'(b), 3'(f), 1'(c), tag(3'(f)));
    // R1: cin has no effect in logic mode
    for (int f = 0; f < 4; f++) begin
      apply(4'hA, 4'h6, 3'(f), 1'b0, "R1");
      r0 = res;
      apply(4'hA, 4'h6, 3'(f), 1'b1, "R1");
      n_run++;
      if (res !== r0 || cout !== 1'b0) begin
        n_fail++;
        $display("FAIL R1: res=%b expected %b cout=%b expected 0", res, r0, cout);
      end
    end
    // R10: full-length ripple corner cases
    apply(4'hF, 4'h0, 3'b110, 1'b1, "R10");
    apply(4'h0, 4'hF, 3'b101, 1'b1, "R10");
    apply(4'h0, 4'h0, 3'b111, 1'b0, "R10");
    apply(4'h0, 4'h0, 3'b100, 1'b1, "R10");
    apply(4'hF, 4'hF, 3'b110, 1'b1, "R10");
    // random vectors with a fixed seed
    void'($urandom(32'd1234));
    for (int k = 0; k < 600; k++) begin
      logic [2:0] rf;
      rf = 3'($urandom);
      apply(4'($urandom), 4'($urandom), rf, 1'($urandom), tag(rf));
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule